// File: doc/BRIEF.md
# Management Frame Master for an Ethernet PHY

This block runs the two-wire management bus of an Ethernet PHY. Software writes one packed 32-bit command word. The word carries the start code, the opcode, the PHY address, the register address, the turnaround bits and a 16-bit data field. That single write sends a complete serial frame on the management clock and data lines. Every frame opens with a preamble of ones and then shifts the command word out MSB first. The management clock runs at the system clock divided by twice a programmable speed value.

At the end of every frame, read or write, the block sets a completion flag. Software clears the flag by writing 1 to it. On a read, the master releases the data line from the first turnaround bit onward and samples the PHY on each rising clock edge. When the frame ends, the 16 sampled bits replace the low half of the command word, where software reads them back.

Top module: `mdio_master`

## Requirements
- R1: After reset, `mdc` is 0, `mdio_oe` is 0, `evt_done` is 0, `cmd_rdata` is 0 and the speed value is 0.
- R2: Command word layout: bits 31:30 are the start code, 29:28 the opcode (10 means read, any other value is sent as a write), 27:23 the PHY address, 22:18 the register address, 17:16 the turnaround bits and 15:0 the data. Each frame is PRE_LEN ones (32 by default) followed by the 32 word bits, MSB first. Each bit is presented on one `mdc` period.
- R3: With speed value S (nonzero), `mdc` has a period of 2*S system clocks and stays high for S of them.
- R4: `mdio_o` and `mdio_oe` change only while `mdc` falls or while it is low. They are stable on every rising edge of `mdc`.
- R5: On a read (opcode 10), `mdio_oe` is 0 from the first turnaround bit to the end of the frame. The PHY level is sampled on the 16 rising edges of the data bits, MSB first. At completion those bits replace `cmd_rdata[15:0]`, and bits 31:16 are unchanged.
- R6: On a write, `mdio_oe` is 1 for all frame bits, and `cmd_rdata` still equals the written word after completion.
- R7: `evt_done` rises exactly 2*S*(PRE_LEN+32) clocks after the clock edge that accepts the command write.
- R8: Writing `evt_wr` with `evt_wdata`=1 clears `evt_done`. Writing it with `evt_wdata`=0 leaves the flag unchanged. A completion in the same cycle as a clear wins.
- R9: A command write while a frame is in progress is ignored. The frame in flight, the frame length and `cmd_rdata` all stay unaffected.
- R10: While the speed value is 0, a command write stores the word (readable on `cmd_rdata`) but starts no frame. `mdc` stays low, `mdio_oe` stays 0 and `evt_done` is not set.
- R11: A speed write while a frame is in progress is ignored, so the frame finishes with the timing of the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 32 | Command word to write |
| cmd_rdata | output | 32 | Stored command word, low half replaced after a read |
| spd_wr | input | 1 | Write strobe for the speed value |
| spd_wdata | input | DIV_W | New speed value (half-period in system clocks) |
| evt_wr | input | 1 | Write strobe for the completion flag |
| evt_wdata | input | 1 | 1 clears the completion flag, 0 does nothing |
| evt_done | output | 1 | Completion flag |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable (tri-state control) |
| mdio_i | input | 1 | Data line level seen from the pad |

## Verification
The bench builds the block with DIV_W=4 and the default 32-bit preamble. It uses speed values 1, 2 and 3, so frames of 128 to 384 clocks still show the full 64-bit frame, the exact completion cycle and the duty cycle. A read with a nonzero data field exercises the replacement of the low half. Speed value 0, which is the reset value, is also within reach and shows the idle hold. A frame with a command write and a speed write inserted mid-way shows that the frame in flight is protected.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CMD_W     = 32;
  localparam int DAT_W     = 16;
  // field positions: the serial order of the frame depends on them
  localparam int OP_HI     = 29;
  localparam int OP_LO     = 28;
  localparam logic [1:0] OP_READ = 2'b10;
  // offset of the first turnaround bit inside the command word, counted from MSB
  localparam int TA_OFS    = 14;
  localparam int DATA_OFS  = 16;
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_stb,
  output logic             fall_stb
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             mdc_q, mdc_d;
  logic             tick;

  assign tick     = run && (cnt_q == div - DIV_W'(1));
  assign rise_stb = tick && !mdc_q;
  assign fall_stb = tick && mdc_q;
  assign mdc      = mdc_q;

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = !mdc_q;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CMD_W-1:0] word,
  input  logic             rise_stb,
  input  logic             fall_stb,
  input  logic             mdio_i,
  output logic             busy,
  output logic             done,
  output logic             is_read,
  output logic [DAT_W-1:0] rd_data,
  output logic             mdio_o,
  output logic             mdio_oe
);
  localparam int FRAME_LEN = PRE_LEN + CMD_W;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] PRE_IDX  = IDX_W'(PRE_LEN);
  localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(PRE_LEN + TA_OFS);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(PRE_LEN + DATA_OFS);

  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [DAT_W-1:0] sr_q, sr_d;
  logic [4:0]       rel;

  assign is_read = (word[OP_HI:OP_LO] == OP_READ);
  assign done    = busy_q && fall_stb && (idx_q == LAST_IDX);
  assign busy    = busy_q;
  assign rd_data = sr_q;
  assign rel     = 5'(idx_q - PRE_IDX);

  // bit presented during the current MDC period
  always_comb begin
    if (!busy_q)
      mdio_o = 1'b0;
    else if (idx_q < PRE_IDX)
      mdio_o = 1'b1;
    else
      mdio_o = word[~rel];
  end

  assign mdio_oe = busy_q && !(is_read && (idx_q >= TA_IDX));

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    sr_d   = sr_q;
    if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      if (rise_stb && is_read && (idx_q >= DAT_IDX))
        sr_d = {sr_q[DAT_W-2:0], mdio_i};
      if (fall_stb) begin
        if (idx_q == LAST_IDX) begin
          busy_d = 1'b0;
          idx_d  = '0;
        end else begin
          idx_d  = idx_q + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      sr_q   <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      sr_q   <= sr_d;
    end
  end
endmodule

// File: rtl/mdio_evt.sv
module mdio_evt (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr_we,
  input  logic clr_bit,
  output logic flag
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_we && clr_bit)
      flag_d = 1'b0;
    if (set)
      flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 6,
  parameter int PRE_LEN = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [31:0]      cmd_wdata,
  output logic [31:0]      cmd_rdata,
  input  logic             spd_wr,
  input  logic [DIV_W-1:0] spd_wdata,
  input  logic             evt_wr,
  input  logic             evt_wdata,
  output logic             evt_done,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  logic [CMD_W-1:0] cmd_q, cmd_d;
  logic [DIV_W-1:0] spd_q, spd_d;
  logic             busy, frm_done, frm_read, start;
  logic             rise_stb, fall_stb;
  logic [DAT_W-1:0] rd_data;

  assign start = cmd_wr && !busy && (spd_q != '0);

  always_comb begin
    cmd_d = cmd_q;
    spd_d = spd_q;
    if (cmd_wr && !busy)
      cmd_d = cmd_wdata;
    else if (frm_done && frm_read)
      cmd_d = {cmd_q[CMD_W-1:DAT_W], rd_data};
    if (spd_wr && !busy)
      spd_d = spd_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      spd_q <= '0;
    end else begin
      cmd_q <= cmd_d;
      spd_q <= spd_d;
    end
  end

  assign cmd_rdata = cmd_q;

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .div      (spd_q),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mdio_frame #(.PRE_LEN(PRE_LEN)) u_frm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .word     (cmd_q),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .done     (frm_done),
    .is_read  (frm_read),
    .rd_data  (rd_data),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
  );

  mdio_evt u_evt (
    .clk     (clk),
    .rst_n   (rst_n),
    .set     (frm_done),
    .clr_we  (evt_wr),
    .clr_bit (evt_wdata),
    .flag    (evt_done)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int DIV_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic [DIV_W-1:0] spd,
  input logic             mdc,
  input logic             mdio_o,
  input logic             mdio_oe,
  input logic             evt_done,
  input logic             evt_wr,
  input logic             evt_wdata,
  input logic [31:0]      cmd_rdata
);
  // R10: no frame while the divider is zero, clock held low when idle
  assert_idle_mdc_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  assert_no_frame_spd0_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (spd == '0) |-> !busy);
  // R4: data line settled across every rising MDC edge
  assert_stable_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));
  // R5: line released whenever no frame runs
  assert_release_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
  // R8: writing zero keeps the flag, writing one clears it
  assert_w1c_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_done && evt_wr && !evt_wdata) |=> evt_done);
  assert_w1c_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_done && evt_wr && evt_wdata && !done) |=> !evt_done);
  // R7: completion always raises the flag
  assert_done_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> evt_done);
  // R9: command word frozen during a frame except for the final read update
  assert_cmd_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(cmd_rdata));
endmodule

bind mdio_master mdio_master_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (frm_done),
  .spd       (spd_q),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .evt_done  (evt_done),
  .evt_wr    (evt_wr),
  .evt_wdata (evt_wdata),
  .cmd_rdata (cmd_rdata)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  localparam int DW  = 4;
  localparam int PRE = 32;
  localparam int FL  = PRE + 32;
  localparam int NV  = 4;

  localparam logic [31:0] V_CMD [NV] = '{
    {2'b01, 2'b01, 5'd3,  5'd0,  2'b10, 16'hA5C3},
    {2'b01, 2'b10, 5'd1,  5'd2,  2'b10, 16'h0000},
    {2'b01, 2'b10, 5'd31, 5'd31, 2'b10, 16'hFFFF},
    {2'b01, 2'b01, 5'd16, 5'd9,  2'b10, 16'h0001}
  };
  localparam logic [DW-1:0] V_SPD [NV] = '{4'd1, 4'd2, 4'd3, 4'd2};
  localparam logic [15:0]   V_RSP [NV] = '{16'h0000, 16'h1234, 16'h8001, 16'h0000};

  logic          clk = 0;
  logic          rst_n = 0;
  logic          cmd_wr = 0;
  logic [31:0]   cmd_wdata = '0;
  logic [31:0]   cmd_rdata;
  logic          spd_wr = 0;
  logic [DW-1:0] spd_wdata = '0;
  logic          evt_wr = 0;
  logic          evt_wdata = 0;
  logic          evt_done, mdc, mdio_o, mdio_oe;
  logic          mdio_i = 1'b1;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  mdio_master #(.DIV_W(DW), .PRE_LEN(PRE)) dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
    .spd_wr(spd_wr), .spd_wdata(spd_wdata),
    .evt_wr(evt_wr), .evt_wdata(evt_wdata), .evt_done(evt_done),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // line monitor and PHY model, evaluated on the falling system edge
  logic        mon_clr = 0;
  logic [15:0] phy_resp = '0;
  logic        mon_bit [FL];
  logic        mon_oe  [FL];
  int          rcnt = 0, nfall = 0, cyc = 0;
  int          rise_t0 = 0, rise_t1 = 0, fall_t0 = 0;
  logic        mdc_prev = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (mon_clr) begin
      rcnt = 0; nfall = 0;
    end else begin
      if (!mdc_prev && mdc) begin
        if (rcnt < FL) begin
          mon_bit[rcnt] = mdio_o;
          mon_oe[rcnt]  = mdio_oe;
        end
        if (rcnt == 0) rise_t0 = cyc;
        if (rcnt == 1) rise_t1 = cyc;
        rcnt = rcnt + 1;
      end
      if (mdc_prev && !mdc) begin
        if (nfall == 0) fall_t0 = cyc;
        nfall = nfall + 1;
      end
    end
    mdc_prev = mdc;
    if (rcnt == PRE + 15)
      mdio_i = 1'b0;
    else if (rcnt >= PRE + 16 && rcnt < FL)
      mdio_i = phy_resp[4'(FL - 1 - rcnt)];
    else
      mdio_i = 1'b1;
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd = wd + 1;
    if (wd > 150000) begin
      n_chk = n_chk + 1;
      n_bad = n_bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", wd);
      summary();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic set_speed(input logic [DW-1:0] s);
    spd_wr = 1; spd_wdata = s; step(); spd_wr = 0;
  endtask

  // issue command, return clocks from accepting edge to completion flag
  task automatic launch(input logic [31:0] w, output int n);
    mon_clr = 1; step(); mon_clr = 0;
    cmd_wr = 1; cmd_wdata = w;
    step();
    cmd_wr = 0;
    n = 0;
    while (!evt_done && n < 5000) begin
      step(); n = n + 1;
    end
  endtask

  task automatic check_frame(input logic [31:0] w, input string tag);
    bit rd = (w[29:28] == 2'b10);
    bit ok_b = 1, ok_o = 1;
    check(rcnt == FL, {tag, " R2 rise count"}, rcnt, FL);
    for (int k = 0; k < FL; k++) begin
      logic eb = (k < PRE) ? 1'b1 : w[FL - 1 - k];
      logic eo = !(rd && k >= PRE + 14);
      if (mon_oe[k] !== eo) ok_o = 0;
      if (eo && mon_bit[k] !== eb) ok_b = 0;
    end
    check(ok_b, {tag, " R2 frame bits"}, ok_b, 1);
    check(ok_o, rd ? {tag, " R5 read release"} : {tag, " R6 write drive"}, ok_o, 1);
  endtask

  initial begin
    int n;
    logic [31:0] exp_w;
    repeat (3) step();
    // R1: reset state
    check(mdc === 1'b0 && mdio_oe === 1'b0, "R1 line idle", {mdc, mdio_oe}, 0);
    check(evt_done === 1'b0, "R1 flag clear", evt_done, 0);
    check(cmd_rdata === 32'h0, "R1 word zero", cmd_rdata, 0);
    rst_n = 1; step();

    // R10: speed still 0 from reset, command stored, no frame
    mon_clr = 1; step(); mon_clr = 0;
    cmd_wr = 1; cmd_wdata = 32'h6ABC_1234; step(); cmd_wr = 0;
    repeat (60) step();
    check(rcnt == 0, "R10 no mdc edge", rcnt, 0);
    check(evt_done === 1'b0 && mdio_oe === 1'b0, "R10 no frame", {evt_done, mdio_oe}, 0);
    check(cmd_rdata === 32'h6ABC_1234, "R10 word stored", cmd_rdata, 32'h6ABC_1234);

    // vector walk: R2 R3 R5 R6 R7
    for (int v = 0; v < NV; v++) begin
      set_speed(V_SPD[v]);
      phy_resp = V_RSP[v];
      launch(V_CMD[v], n);
      check(n == 2 * int'(V_SPD[v]) * FL, "R7 completion cycle", n, 2 * int'(V_SPD[v]) * FL);
      check_frame(V_CMD[v], "vec");
      check(rise_t1 - rise_t0 == 2 * int'(V_SPD[v]), "R3 mdc period", rise_t1 - rise_t0, 2 * int'(V_SPD[v]));
      check(fall_t0 - rise_t0 == int'(V_SPD[v]), "R3 mdc high time", fall_t0 - rise_t0, int'(V_SPD[v]));
      exp_w = (V_CMD[v][29:28] == 2'b10) ? {V_CMD[v][31:16], V_RSP[v]} : V_CMD[v];
      check(cmd_rdata === exp_w, (V_CMD[v][29:28] == 2'b10) ? "R5 read data" : "R6 word kept",
            cmd_rdata, exp_w);
      evt_wr = 1; evt_wdata = 1; step(); evt_wr = 0;
    end

    // R8: write-1-to-clear semantics
    set_speed(4'd1);
    launch(V_CMD[0], n);
    evt_wr = 1; evt_wdata = 0; step(); evt_wr = 0; step();
    check(evt_done === 1'b1, "R8 zero write keeps flag", evt_done, 1);
    evt_wr = 1; evt_wdata = 1; step(); evt_wr = 0; step();
    check(evt_done === 1'b0, "R8 one write clears flag", evt_done, 0);

    // R9 and R11: writes during a frame
    mon_clr = 1; step(); mon_clr = 0;
    cmd_wr = 1; cmd_wdata = V_CMD[3]; step(); cmd_wr = 0;
    repeat (40) step();
    cmd_wr = 1; cmd_wdata = 32'h5FFF_0000; step(); cmd_wr = 0;
    spd_wr = 1; spd_wdata = 4'd3; step(); spd_wr = 0;
    n = 42;
    while (!evt_done && n < 5000) begin step(); n = n + 1; end
    check(n == 2 * FL, "R11 old speed kept", n, 2 * FL);
    check_frame(V_CMD[3], "busy-write R9");
    check(cmd_rdata === V_CMD[3], "R9 word unchanged", cmd_rdata, V_CMD[3]);
    evt_wr = 1; evt_wdata = 1; step(); evt_wr = 0;
    launch(V_CMD[0], n);
    check(n == 2 * FL, "R11 speed write dropped", n, 2 * FL);

    summary();
    $finish;
  end
endmodule